// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit logical address into a physical address by reading two levels of page-table entries from memory. It is called when a translation is missing. Pages are 1 KiB, so the low ten address bits are the offset within the page. The 22-bit page number above them is split in two. The upper twelve bits index the outer table, and the ten bits below them index an inner table. A base input gives the byte address of the outer table. A length input bounds how many outer entries exist.

Each entry is 32 bits wide. Bit 0 is the valid flag. For an outer entry, bits [31:12] locate the inner table, which is aligned to 4 KiB. For an inner entry, bits [31:10] are the frame number. The walker holds one request at a time and has at most one memory read in flight. When the walk ends it gives a one-cycle response. The response carries either the physical address, or a fault together with the level that failed.

The controller has five states. `WS_IDLE` waits for a request. Acceptance goes to `WS_READ_OUTER`, or straight to `WS_FAULT` when the length check fails. `WS_READ_OUTER` waits for the outer entry. A valid entry goes to `WS_READ_INNER` and an invalid one goes to `WS_FAULT`. `WS_READ_INNER` waits for the inner entry. A valid entry goes to `WS_DONE` and an invalid one goes to `WS_FAULT`. Both `WS_DONE` and `WS_FAULT` return to `WS_IDLE` after one cycle.

Top module: `pt_walker`

## Requirements
- R1: On a successful walk, bits [9:0] of `rsp_paddr` equal bits [9:0] of the accepted logical address.
- R2: The first read after acceptance is issued in the next cycle, at address `root_base + 4 * vaddr[31:20]`.
- R3: After a valid outer entry E, the second read is issued in the next cycle at address `{E[31:12], vaddr[19:10], 2'b00}`. Bits [11:1] of E do not affect it.
- R4: On a successful walk, `rsp_paddr[31:10]` equals bits [31:10] of the valid inner entry. Bits [9:1] of that entry do not affect the result.
- R5: If `vaddr[31:20]` is greater than or equal to `root_len`, the response follows acceptance by one cycle with `rsp_fault`=1 and `rsp_fault_kind`=1, and no memory read is issued. An index of `root_len`-1 passes the check.
- R6: An outer entry with bit 0 clear ends the walk. The next cycle gives a fault with `rsp_fault_kind`=2, and no second read is issued.
- R7: An inner entry with bit 0 clear ends the walk. The next cycle gives a fault with `rsp_fault_kind`=3.
- R8: `req_ready` is low from the cycle after acceptance until the walk returns to idle. Changes on the request inputs during that time have no effect on the walk.
- R9: `mem_req_valid` is a one-cycle pulse, and no new read is issued until the response to the previous read has arrived.
- R10: After reset, `req_ready`=1 and `rsp_valid`=0 and `mem_req_valid`=0. Each response is a one-cycle `rsp_valid` pulse, with `rsp_fault_kind`=0 on success, followed by `req_ready`=1.
- R11: A `mem_rsp_valid` that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; the request is accepted this cycle |
| req_vaddr | input | 32 | Logical address to translate |
| root_base | input | 32 | Byte address of the outer table; sampled when a request is accepted |
| root_len | input | 13 | Number of outer entries; sampled when a request is accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | The response is a fault |
| rsp_fault_kind | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |
| rsp_paddr | output | 32 | Translated physical address |
| mem_req_valid | output | 1 | One-cycle memory read strobe |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The assertions assume that memory returns exactly one `mem_rsp_valid` for each read, and never in the same cycle as the read strobe. They also assume that a response seen while no read is pending carries no meaning. The bench memory answers each read once, after a chosen delay of zero or more cycles. It injects stray responses only while the walker is idle and no request is being driven. The bench holds `root_base` and `root_len` steady through each walk, and perturbs the address only after the walker has accepted it.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_READ_OUTER,
        WS_READ_INNER,
        WS_DONE,
        WS_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_LENGTH = 2'd1,
        FK_OUTER  = 2'd2,
        FK_INNER  = 2'd3
    } fault_kind_t;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
    parameter int VA_W     = 32,
    parameter int OFF_BITS = 10,
    parameter int IN_BITS  = 10,
    parameter int OUT_BITS = VA_W - OFF_BITS - IN_BITS
) (
    input  logic [VA_W-1:0]     vaddr,
    input  logic [OUT_BITS:0]   root_len,
    output logic [OUT_BITS-1:0] outer_idx,
    output logic [IN_BITS-1:0]  inner_idx,
    output logic [OFF_BITS-1:0] offset,
    output logic                out_of_range
);

    localparam int IN_LO  = OFF_BITS;
    localparam int OUT_LO = OFF_BITS + IN_BITS;

    always_comb begin
        offset       = vaddr[OFF_BITS-1:0];
        inner_idx    = vaddr[IN_LO +: IN_BITS];
        outer_idx    = vaddr[OUT_LO +: OUT_BITS];
        // R5: indices at or past the table length are rejected
        out_of_range = ({1'b0, outer_idx} >= root_len);
    end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
    import pt_walker_pkg::*;
#(
    parameter int PA_W     = 32,
    parameter int OFF_BITS = 10,
    parameter int IN_BITS  = 10,
    parameter int OUT_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [OUT_BITS-1:0] outer_idx,
    input  logic [IN_BITS-1:0]  inner_idx,
    input  logic [OFF_BITS-1:0] offset,
    input  logic                out_of_range,
    input  logic [PA_W-1:0]     root_base,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [1:0]          rsp_fault_kind,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic                mem_req_valid,
    output logic [PA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [PA_W-1:0]     mem_rsp_data
);

    localparam int ENTRY_SH = 2;
    localparam int TBL_LO   = IN_BITS + ENTRY_SH;

    walk_state_t          state_q, state_d;
    fault_kind_t          kind_q;
    logic [IN_BITS-1:0]   inner_q;
    logic [OFF_BITS-1:0]  off_q;
    logic                 issue_q;
    logic [PA_W-1:0]      addr_q;
    logic [PA_W-1:0]      paddr_q;
    logic                 entry_ok;
    logic                 unused_entry_bits;

    assign entry_ok          = mem_rsp_data[0];
    assign unused_entry_bits = &{1'b0, mem_rsp_data[OFF_BITS-1:1]};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:       if (req_valid)
                               state_d = out_of_range ? WS_FAULT : WS_READ_OUTER;
            WS_READ_OUTER: if (mem_rsp_valid)
                               state_d = entry_ok ? WS_READ_INNER : WS_FAULT;
            WS_READ_INNER: if (mem_rsp_valid)
                               state_d = entry_ok ? WS_DONE : WS_FAULT;
            WS_DONE:       state_d = WS_IDLE;
            WS_FAULT:      state_d = WS_IDLE;
            default:       state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            kind_q  <= FK_NONE;
            inner_q <= '0;
            off_q   <= '0;
            issue_q <= 1'b0;
            addr_q  <= '0;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            issue_q <= 1'b0;
            unique case (state_q)
                WS_IDLE: if (req_valid) begin
                    inner_q <= inner_idx;
                    off_q   <= offset;
                    if (out_of_range) begin
                        kind_q <= FK_LENGTH;
                    end else begin
                        kind_q  <= FK_NONE;
                        issue_q <= 1'b1;
                        addr_q  <= root_base + PA_W'({outer_idx, 2'b00});
                    end
                end
                WS_READ_OUTER: if (mem_rsp_valid) begin
                    if (entry_ok) begin
                        issue_q <= 1'b1;
                        addr_q  <= {mem_rsp_data[PA_W-1:TBL_LO], inner_q, 2'b00};
                    end else begin
                        kind_q <= FK_OUTER;
                    end
                end
                WS_READ_INNER: if (mem_rsp_valid) begin
                    if (entry_ok) paddr_q <= {mem_rsp_data[PA_W-1:OFF_BITS], off_q};
                    else          kind_q  <= FK_INNER;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready      = (state_q == WS_IDLE);
        rsp_valid      = (state_q == WS_DONE) || (state_q == WS_FAULT);
        rsp_fault      = (state_q == WS_FAULT);
        rsp_fault_kind = (state_q == WS_FAULT) ? kind_q : FK_NONE;
        rsp_paddr      = paddr_q;
        mem_req_valid  = issue_q;
        mem_req_addr   = addr_q;
    end

    assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    assert_len_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && out_of_range) |=>
            (rsp_valid && rsp_fault && rsp_fault_kind == 2'd1 && !mem_req_valid));

    assert_outer_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !out_of_range) |=>
            (mem_req_valid && mem_req_addr == $past(root_base) + PA_W'({$past(outer_idx), 2'b00})));

    assert_outer_inval_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_READ_OUTER && mem_rsp_valid && !mem_rsp_data[0]) |=>
            (rsp_fault && rsp_fault_kind == 2'd2 && !mem_req_valid));

    assert_inner_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_READ_INNER && mem_rsp_valid && !mem_rsp_data[0]) |=>
            (rsp_fault && rsp_fault_kind == 2'd3));

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int VA_W     = 32,
    parameter int PA_W     = 32,
    parameter int OFF_BITS = 10,
    parameter int IN_BITS  = 10,
    localparam int OUT_BITS = VA_W - OFF_BITS - IN_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [PA_W-1:0]     root_base,
    input  logic [OUT_BITS:0]   root_len,
    output logic                rsp_valid,
    output logic                rsp_fault,
    output logic [1:0]          rsp_fault_kind,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic                mem_req_valid,
    output logic [PA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [PA_W-1:0]     mem_rsp_data
);

    logic [OUT_BITS-1:0] outer_idx;
    logic [IN_BITS-1:0]  inner_idx;
    logic [OFF_BITS-1:0] offset;
    logic                out_of_range;

    pt_va_split #(
        .VA_W(VA_W), .OFF_BITS(OFF_BITS), .IN_BITS(IN_BITS), .OUT_BITS(OUT_BITS)
    ) u_split (
        .vaddr(req_vaddr), .root_len(root_len), .outer_idx(outer_idx),
        .inner_idx(inner_idx), .offset(offset), .out_of_range(out_of_range)
    );

    pt_walk_ctrl #(
        .PA_W(PA_W), .OFF_BITS(OFF_BITS), .IN_BITS(IN_BITS), .OUT_BITS(OUT_BITS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .outer_idx(outer_idx), .inner_idx(inner_idx), .offset(offset),
        .out_of_range(out_of_range), .root_base(root_base),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_fault_kind(rsp_fault_kind), .rsp_paddr(rsp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] root_base = '0;
    logic [12:0] root_len = '0;
    logic        rsp_valid, rsp_fault;
    logic [1:0]  rsp_fault_kind;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #10 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_base(root_base), .root_len(root_len),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_kind(rsp_fault_kind),
        .rsp_paddr(rsp_paddr), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] mem [int unsigned];

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder: one reply per read after lat cycles; optional stray replies
    int          lat = 0;
    bit          stray = 1'b0;
    bit          pend = 1'b0;
    int          cnt = 0;
    logic [31:0] cap = '0;

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(cap);
                pend = 1'b0;
            end else cnt--;
        end else if (stray) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 32'hFFFF_FFFF;
        end
        if (rst_n && mem_req_valid) begin
            pend = 1'b1;
            cnt  = lat;
            cap  = mem_req_addr;
        end
    end

    // Cycle reference model: 0 idle, 1 outer wait, 2 inner wait, 3 done, 4 fault
    int          ms = 0;
    bit          m_issue = 1'b0;
    logic [31:0] m_addr = '0, m_paddr = '0, m_v = '0;
    int          m_kind = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; m_issue = 1'b0; m_kind = 0;
        end else begin
            bit nxt_issue;
            nxt_issue = 1'b0;
            case (ms)
                0: if (req_valid) begin
                    m_v = req_vaddr;
                    if (int'(req_vaddr[31:20]) >= int'(root_len)) begin
                        ms = 4; m_kind = 1;
                    end else begin
                        ms = 1; nxt_issue = 1'b1; m_kind = 0;
                        m_addr = root_base + {18'h0, req_vaddr[31:20], 2'b00};
                    end
                end
                1: if (mem_rsp_valid) begin
                    if (!mem_rsp_data[0]) begin ms = 4; m_kind = 2; end
                    else begin
                        ms = 2; nxt_issue = 1'b1;
                        m_addr = {mem_rsp_data[31:12], m_v[19:10], 2'b00};
                    end
                end
                2: if (mem_rsp_valid) begin
                    if (!mem_rsp_data[0]) begin ms = 4; m_kind = 3; end
                    else begin ms = 3; m_paddr = {mem_rsp_data[31:10], m_v[9:0]}; end
                end
                default: ms = 0;
            endcase
            m_issue = nxt_issue;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(req_ready == (ms == 0), "R8 req_ready", {31'h0, req_ready}, {31'h0, ms == 0});
            check(mem_req_valid == m_issue, "R9 mem_req_valid", {31'h0, mem_req_valid}, {31'h0, m_issue});
            if (m_issue) check(mem_req_addr == m_addr, "R2 R3 entry address", mem_req_addr, m_addr);
            check(rsp_valid == (ms >= 3), "R10 rsp_valid", {31'h0, rsp_valid}, {31'h0, ms >= 3});
            check(rsp_fault == (ms == 4), "R5 R6 R7 rsp_fault", {31'h0, rsp_fault}, {31'h0, ms == 4});
            if (ms >= 3) check(rsp_fault_kind == m_kind[1:0], "R5 R6 R7 fault kind",
                               {30'h0, rsp_fault_kind}, m_kind);
            if (ms == 3) check(rsp_paddr == m_paddr, "R1 R4 paddr", rsp_paddr, m_paddr);
        end
    end

    // Transaction-level expectation from the requirements
    task automatic walk(input logic [31:0] v, input logic [31:0] base, input logic [12:0] len,
                        input int l, input bit noise, input string tag);
        int          ek;
        logic [31:0] oe, ie, ep;
        int          guard;
        ep = '0;
        if (int'(v[31:20]) >= int'(len)) ek = 1;
        else begin
            oe = rd(base + {18'h0, v[31:20], 2'b00});
            if (!oe[0]) ek = 2;
            else begin
                ie = rd({oe[31:12], v[19:10], 2'b00});
                if (!ie[0]) ek = 3;
                else begin ek = 0; ep = {ie[31:10], v[9:0]}; end
            end
        end
        @(negedge clk);
        lat = l; root_base = base; root_len = len;
        req_valid = 1'b1; req_vaddr = v;
        guard = 0;
        do begin
            @(negedge clk);
            if (noise) req_vaddr = ~v;
            guard++;
        end while (!rsp_valid && guard < 100);
        check(rsp_valid, {tag, " response seen"}, {31'h0, rsp_valid}, 32'h1);
        check(rsp_fault_kind == ek[1:0], {tag, " kind"}, {30'h0, rsp_fault_kind}, ek);
        check(rsp_fault == (ek != 0), {tag, " fault flag"}, {31'h0, rsp_fault}, {31'h0, ek != 0});
        if (ek == 0) check(rsp_paddr == ep, {tag, " paddr"}, rsp_paddr, ep);
        req_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<50000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mem[32'h0001_000C] = {20'h00020, 12'hABF};
        mem[32'h0002_0014] = {22'h12345, 10'h3FF};
        mem[32'h0001_003C] = {20'h00030, 12'h001};
        mem[32'h0003_0000] = {22'h3FFFFF, 10'h001};
        mem[32'h0004_0000] = {20'h00050, 12'h001};
        mem[32'h0005_0FFC] = {22'h000001, 10'h001};

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R10 reset ready", {31'h0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R10 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check(mem_req_valid == 1'b0, "R10 reset mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        walk({12'd3, 10'd5, 10'h2AB}, 32'h0001_0000, 13'd16, 0, 1'b0, "R1 R3 R4 success");
        walk({12'd3, 10'd5, 10'h155}, 32'h0001_0000, 13'd16, 3, 1'b1, "R8 busy success");
        walk({12'd4, 10'd5, 10'h001}, 32'h0001_0000, 13'd16, 1, 1'b0, "R6 outer invalid");
        walk({12'd3, 10'd6, 10'h001}, 32'h0001_0000, 13'd16, 2, 1'b0, "R7 inner invalid");
        walk({12'd20, 10'd0, 10'h000}, 32'h0001_0000, 13'd16, 0, 1'b0, "R5 beyond length");
        walk({12'd15, 10'd0, 10'h0F0}, 32'h0001_0000, 13'd16, 0, 1'b0, "R5 last index ok");
        walk({12'd16, 10'd0, 10'h0F0}, 32'h0001_0000, 13'd16, 0, 1'b0, "R5 index equals length");
        walk({12'd0, 10'd0, 10'h000}, 32'h0001_0000, 13'd0, 0, 1'b0, "R5 zero length");
        walk({12'd4095, 10'd0, 10'h000}, 32'h0001_0000, 13'd4096, 1, 1'b0, "R5 R6 full length");

        @(posedge clk); stray = 1'b1;
        repeat (3) @(posedge clk);
        stray = 1'b0;
        @(negedge clk); @(negedge clk);
        check(req_ready == 1'b1, "R11 stray ignored ready", {31'h0, req_ready}, 32'h1);
        check(rsp_valid == 1'b0, "R11 stray ignored rsp", {31'h0, rsp_valid}, 32'h0);

        walk({12'd0, 10'd1023, 10'h3FF}, 32'h0004_0000, 13'd1, 2, 1'b0, "R1 R2 R4 other base");
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule